// File: doc/BRIEF.md
# Per-Channel Clock Blocking Generator

This block produces two gating outputs for a framed serial stream of 32 timeslots, one for the receive side and one for the transmit side. Each side holds a 32-bit channel mask, one bit per channel, spread over four 8-bit registers that a host writes and reads by 8-bit address. From a bit-clock strobe and a frame-sync input, each side tracks the current channel. For the whole of that channel's eight bit times it drives its gating output to the channel's mask bit. The output can then gate the clock of a downstream serial controller, so that the controller sees only the channels it owns.

The transmit mask has a second use. When a mode bit in a separate control register is set, the output `tx_sig_int` tells the signaling insertion logic, channel by channel, to take signaling bits from the internal signaling registers (1) or from the serial transmit data input (0). When the mode bit is clear, `tx_sig_int` stays 0.

All logic runs on one system clock. The per-side bit clocks reach the block as one-cycle strobes. Mask and mode values are sampled only at channel boundaries, so a host write made partway through a channel never changes an output before that channel ends.

Top module: `chblk_gen`

## Requirements
- R1: After reset, `rx_chblk`, `tx_chblk` and `tx_sig_int` are 0, and every register address listed in R2 reads back 0.
- R2: The host writes an 8-bit register on a cycle with `host_we`=1. Receive mask registers sit at 0x2B..0x2E, transmit mask registers at 0x22..0x25, and the control register at 0x30, where the mode is bit 0. `host_rdata` returns the stored value of the addressed register in the same cycle. Unused bits and unmapped addresses read 0.
- R3: Channel n (1..32) is bit (n-1) mod 8 of mask register (n-1) div 8, counted from the base address. Bit 0 of the first register is channel 1, and bit 7 of the fourth is channel 32.
- R4: A side's gating output changes only on the bit strobe that starts a channel, and is visible in the cycle after that strobe. It then holds that channel's mask bit through all 8 bit times of the channel.
- R5: A bit strobe with frame sync high starts channel 1, bit 0, at any point in the frame.
- R6: Without frame sync, the count runs from channel 32 bit 7 on to channel 1. Out of reset, the first strobe without frame sync starts channel 1.
- R7: `rx_chblk` depends only on the receive mask and receive strobes. `tx_chblk` and `tx_sig_int` depend only on the transmit mask, the mode bit and the transmit strobes.
- R8: A mask or mode write made partway through a channel does not affect the outputs before the next channel boundary.
- R9: With mode=1, `tx_sig_int` equals the current transmit channel's mask bit. With mode=0, `tx_sig_int` is 0 while `tx_chblk` still follows the mask.
- R10: In cycles without a side's bit strobe, that side's outputs and channel position hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr |
| rx_bclk_en | input | 1 | Receive bit strobe, one cycle per bit |
| rx_fsync | input | 1 | Receive frame sync, qualified by rx_bclk_en |
| tx_bclk_en | input | 1 | Transmit bit strobe, one cycle per bit |
| tx_fsync | input | 1 | Transmit frame sync, qualified by tx_bclk_en |
| rx_chblk | output | 1 | Receive channel gating output |
| tx_chblk | output | 1 | Transmit channel gating output |
| tx_sig_int | output | 1 | 1: signaling from internal registers; 0: from serial input |

## Verification
A wrong channel or bit counter shows up as a gating pattern shifted by whole channels, or with a boundary that is off by some bits. The bench compares every output after every strobe against a frame position it tracks itself, so such an error is reported at the first boundary that lands in the wrong place. A mask bit stored in the wrong place, or a mode bit read at the wrong time, appears within one frame as a mismatch on the channel concerned. A write that leaks through mid-channel is reported on the very next strobe.

// File: rtl/chblk_gen.sv
module chblk_gen #(
  parameter int         N_CH        = 32,
  parameter int         BITS_PER_CH = 8,
  parameter logic [7:0] RX_BASE     = 8'h2B,
  parameter logic [7:0] TX_BASE     = 8'h22,
  parameter logic [7:0] CTL_ADDR    = 8'h30,
  parameter int         MODE_BIT    = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       rx_bclk_en,
  input  logic       rx_fsync,
  input  logic       tx_bclk_en,
  input  logic       tx_fsync,
  output logic       rx_chblk,
  output logic       tx_chblk,
  output logic       tx_sig_int
);
  localparam int NREG  = N_CH / 8;
  localparam int CH_W  = $clog2(N_CH);
  localparam int BIT_W = $clog2(BITS_PER_CH);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS_PER_CH - 1);
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(N_CH - 1);

  logic [N_CH-1:0] rx_mask, tx_mask;
  logic            sig_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_mask  <= '0;
      tx_mask  <= '0;
      sig_mode <= 1'b0;
    end else if (host_we) begin
      for (int i = 0; i < NREG; i++) begin
        if (host_addr == RX_BASE + 8'(i)) rx_mask[i*8 +: 8] <= host_wdata;
        if (host_addr == TX_BASE + 8'(i)) tx_mask[i*8 +: 8] <= host_wdata;
      end
      if (host_addr == CTL_ADDR) sig_mode <= host_wdata[MODE_BIT];
    end
  end

  always_comb begin
    host_rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (host_addr == RX_BASE + 8'(i)) host_rdata = rx_mask[i*8 +: 8];
      if (host_addr == TX_BASE + 8'(i)) host_rdata = tx_mask[i*8 +: 8];
    end
    if (host_addr == CTL_ADDR) host_rdata[MODE_BIT] = sig_mode;
  end

  logic [BIT_W-1:0] rx_bit, tx_bit;
  logic [CH_W-1:0]  rx_ch, tx_ch, rx_next_ch, tx_next_ch;
  logic             rx_edge, tx_edge;

  assign rx_edge    = rx_bclk_en & (rx_fsync | (rx_bit == BIT_LAST));
  assign tx_edge    = tx_bclk_en & (tx_fsync | (tx_bit == BIT_LAST));
  assign rx_next_ch = (rx_fsync || rx_ch == CH_LAST) ? '0 : rx_ch + 1'b1;
  assign tx_next_ch = (tx_fsync || tx_ch == CH_LAST) ? '0 : tx_ch + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_bit   <= BIT_LAST;
      rx_ch    <= CH_LAST;
      rx_chblk <= 1'b0;
    end else if (rx_bclk_en) begin
      rx_bit <= (rx_fsync || rx_bit == BIT_LAST) ? '0 : rx_bit + 1'b1;
      if (rx_edge) begin
        rx_ch    <= rx_next_ch;
        rx_chblk <= rx_mask[rx_next_ch];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_bit     <= BIT_LAST;
      tx_ch      <= CH_LAST;
      tx_chblk   <= 1'b0;
      tx_sig_int <= 1'b0;
    end else if (tx_bclk_en) begin
      tx_bit <= (tx_fsync || tx_bit == BIT_LAST) ? '0 : tx_bit + 1'b1;
      if (tx_edge) begin
        tx_ch      <= tx_next_ch;
        tx_chblk   <= tx_mask[tx_next_ch];
        tx_sig_int <= sig_mode & tx_mask[tx_next_ch];
      end
    end
  end
endmodule

// File: rtl/chblk_gen_chk.sv
module chblk_gen_chk #(
  parameter int         N_CH  = 32,
  parameter int         BIT_W = 3,
  parameter logic [7:0] RX_BASE = 8'h2B
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_we,
  input logic [7:0]       host_addr,
  input logic [7:0]       host_wdata,
  input logic             rx_bclk_en,
  input logic             rx_fsync,
  input logic             tx_bclk_en,
  input logic             tx_fsync,
  input logic [BIT_W-1:0] rx_bit,
  input logic [BIT_W-1:0] tx_bit,
  input logic [N_CH-1:0]  rx_mask,
  input logic             rx_chblk,
  input logic             tx_chblk,
  input logic             tx_sig_int
);
  localparam logic [BIT_W-1:0] LAST = '1;

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_bclk_en && (rx_fsync || rx_bit == LAST)) |=> $stable(rx_chblk));

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_bclk_en && (tx_fsync || tx_bit == LAST)) |=> ($stable(tx_chblk) && $stable(tx_sig_int)));

  assert_frame_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_bclk_en && rx_fsync) |=> (rx_chblk == $past(rx_mask[0])));

  assert_sig_needs_blk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sig_int |-> tx_chblk);

  assert_rx_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == RX_BASE) |=> (rx_mask[7:0] == $past(host_wdata)));

  assert_rx_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_bclk_en |=> $stable(rx_bit));
endmodule

bind chblk_gen chblk_gen_chk #(.N_CH(N_CH), .BIT_W(BIT_W), .RX_BASE(RX_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .rx_bclk_en(rx_bclk_en), .rx_fsync(rx_fsync),
  .tx_bclk_en(tx_bclk_en), .tx_fsync(tx_fsync), .rx_bit(rx_bit),
  .tx_bit(tx_bit), .rx_mask(rx_mask), .rx_chblk(rx_chblk),
  .tx_chblk(tx_chblk), .tx_sig_int(tx_sig_int)
);

// File: tb/tb_chblk_gen.sv
`timescale 1ns/1ps
module tb_chblk_gen;
  localparam int RXB = 'h2B, TXB = 'h22, CTL = 'h30;

  logic clk = 0, rst_n = 0;
  logic host_we = 0;
  logic [7:0] host_addr = 0, host_wdata = 0, host_rdata;
  logic rx_bclk_en = 0, rx_fsync = 0, tx_bclk_en = 0, tx_fsync = 0;
  logic rx_chblk, tx_chblk, tx_sig_int;

  int nchk = 0, nbad = 0;
  bit done = 0;
  int rpos = 255, tpos = 255;
  logic [31:0] rm = 0, tm = 0;
  logic mode = 0, exp_rx = 0, exp_tx = 0, exp_sig = 0;

  always #2 clk = ~clk;

  chblk_gen dut (.*);

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    check(req, "rx_chblk", 32'(rx_chblk), 32'(exp_rx));
    check(req, "tx_chblk", 32'(tx_chblk), 32'(exp_tx));
    check(req, "tx_sig_int", 32'(tx_sig_int), 32'(exp_sig));
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    host_we = 1; host_addr = 8'(a); host_wdata = d;
    @(negedge clk);
    host_we = 0;
    if (a >= RXB && a < RXB + 4) rm[(a - RXB)*8 +: 8] = d;
    if (a >= TXB && a < TXB + 4) tm[(a - TXB)*8 +: 8] = d;
    if (a == CTL) mode = d[0];
  endtask

  task automatic rd(string req, int a, logic [7:0] exp);
    @(negedge clk);
    host_addr = 8'(a);
    #1 check(req, $sformatf("read %0h", a), 32'(host_rdata), 32'(exp));
  endtask

  task automatic tick(string req, bit r, bit rf, bit t, bit tf);
    @(negedge clk);
    rx_bclk_en = r; rx_fsync = rf; tx_bclk_en = t; tx_fsync = tf;
    @(negedge clk);
    rx_bclk_en = 0; rx_fsync = 0; tx_bclk_en = 0; tx_fsync = 0;
    if (r) begin
      rpos = rf ? 0 : (rpos + 1) % 256;
      if (rpos % 8 == 0) exp_rx = rm[rpos/8];
    end
    if (t) begin
      tpos = tf ? 0 : (tpos + 1) % 256;
      if (tpos % 8 == 0) begin exp_tx = tm[tpos/8]; exp_sig = mode & tm[tpos/8]; end
    end
    check_outs(req);
  endtask

  task automatic frame(string req, bit r, bit t);
    for (int i = 0; i < 256; i++) tick(req, r, r && i == 0, t, t && i == 0);
  endtask

  task automatic test_reset;
    check_outs("R1");
    for (int i = 0; i < 4; i++) begin rd("R1", RXB + i, 0); rd("R1", TXB + i, 0); end
    rd("R1", CTL, 0);
  endtask

  task automatic test_regs;
    for (int i = 0; i < 4; i++) begin wr(RXB + i, 8'(8'h11 * (i + 1))); wr(TXB + i, 8'(8'hA0 + i)); end
    wr(CTL, 8'hFF);
    for (int i = 0; i < 4; i++) begin rd("R2", RXB + i, 8'(8'h11 * (i + 1))); rd("R2", TXB + i, 8'(8'hA0 + i)); end
    rd("R2", CTL, 8'h01);
    rd("R2", 'h26, 0);
    rd("R2", 'h2A, 0);
    rd("R2", 'h31, 0);
    wr(CTL, 0);
  endtask

  task automatic test_map;
    for (int i = 0; i < 4; i++) begin wr(RXB + i, 0); wr(TXB + i, 0); end
    wr(RXB + 2, 8'h01);
    wr(TXB + 3, 8'h80);
    wr(TXB, 8'h01);
    frame("R3", 1, 1);
  endtask

  task automatic test_frame;
    wr(RXB, 8'h81); wr(RXB + 1, 8'h0F); wr(RXB + 2, 8'hC3); wr(RXB + 3, 8'hA5);
    wr(TXB, 8'hE1); wr(TXB + 1, 8'h96); wr(TXB + 2, 8'h5A); wr(TXB + 3, 8'h3C);
    frame("R4", 1, 1);
    for (int i = 0; i < 101; i++) tick("R4", 1, 0, 1, 0);
    tick("R5", 1, 1, 1, 0);
    for (int i = 0; i < 40; i++) tick("R5", 1, 0, 1, 0);
    tick("R5", 0, 0, 1, 1);
    for (int i = 0; i < 30; i++) tick("R5", 1, 0, 1, 0);
  endtask

  task automatic test_wrap;
    for (int i = 0; i < 320; i++) tick("R6", 1, 0, 1, 0);
  endtask

  task automatic test_indep;
    frame("R7", 1, 1);
    for (int i = 0; i < 4; i++) wr(RXB + i, 8'hFF);
    frame("R7", 1, 1);
    for (int i = 0; i < 4; i++) wr(TXB + i, 8'h00);
    for (int i = 0; i < 4; i++) wr(RXB + i, 8'h5A);
    frame("R7", 1, 1);
  endtask

  task automatic test_midwrite;
    for (int i = 0; i < 4; i++) begin wr(RXB + i, 0); wr(TXB + i, 0); end
    tick("R8", 1, 1, 1, 1);
    for (int i = 0; i < 3; i++) tick("R8", 1, 0, 1, 0);
    wr(RXB, 8'h03); wr(TXB, 8'h03); wr(CTL, 8'h01);
    for (int i = 0; i < 252; i++) tick("R8", 1, 0, 1, 0);
    wr(CTL, 0);
  endtask

  task automatic test_mode;
    wr(TXB, 8'h5C); wr(TXB + 1, 8'hF0); wr(TXB + 2, 8'h0F); wr(TXB + 3, 8'h81);
    frame("R9", 0, 1);
    wr(CTL, 8'h01);
    frame("R9", 0, 1);
    wr(CTL, 8'h00);
    frame("R9", 0, 1);
  endtask

  task automatic test_idle;
    wr(RXB, 8'h01); wr(TXB, 8'h01); wr(CTL, 8'h01);
    tick("R10", 1, 1, 1, 1);
    for (int i = 0; i < 20; i++) begin @(negedge clk); check_outs("R10"); end
    wr(RXB, 0); wr(TXB, 0);
    for (int i = 0; i < 7; i++) tick("R10", 1, 0, 1, 0);
    tick("R10", 1, 0, 1, 0);
  endtask

  initial begin
    #9 rst_n = 1;
    test_reset();
    test_regs();
    test_map();
    test_frame();
    test_wrap();
    test_indep();
    test_midwrite();
    test_mode();
    test_idle();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      nchk++; nbad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule